// File: doc/BRIEF.md
# SCSI Connection Status LED Driver

This block keeps a single "connected" flag that tells whether the controller currently holds a connection on the SCSI bus, in either the initiator or the target role. Single-cycle event pulses from the bus sequencer set the flag. Disconnect and bus-reset pulses clear it. The flag is reported as one bit of an 8-bit status byte.

The block also owns one general-purpose pin that can serve as an activity LED. The pin is handed to hardware only when three conditions hold together: the LED enable bit of the pin control byte is set, the fetch enable bit of the same byte is clear, and no serial-EEPROM autodownload is in progress. While all three hold, the pin shows the connected flag and is always driven. When any of them fails, the pin and every other pin of the group follow the ordinary software data and direction registers. All pin outputs are registered.

Top module: `scsi_link_led`

## Requirements
- R1: After reset, `connected`, `status_byte`, `pin_out` and `pin_oe` are all zero.
- R2: An `ev_sel_done` pulse (selection completed as initiator) sets `connected` at the next rising clock edge.
- R3: An `ev_resp_sel` pulse (successful response to a selection or reselection as target) sets `connected` at the next rising clock edge.
- R4: An `ev_arb_won_ll` pulse (arbitration won in low-level mode) sets `connected` at the next rising clock edge.
- R5: An `ev_disconnect` pulse or an `ev_bus_reset` pulse clears `connected` at the next rising clock edge.
- R6: A clear event takes priority over a set event in the same cycle, so `connected` is 0 after that edge.
- R7: `status_byte` bit 3 equals `connected`, and its other seven bits are 0.
- R8: LED mode is active when `pin_ctrl` bit 5 (LED enable) is 1, `pin_ctrl` bit 6 (fetch enable) is 0 and `autoload_busy` is 0. In this mode, `pin_out[LED_PIN]` takes the value `connected` had before the edge, one clock later.
- R9: In LED mode, `pin_oe[LED_PIN]` is 1 after the next edge, whatever `gpio_dir[LED_PIN]` holds.
- R10: When any LED-mode condition fails, `pin_out[LED_PIN]` and `pin_oe[LED_PIN]` take `gpio_dout[LED_PIN]` and `gpio_dir[LED_PIN]` one clock later. `gpio_dir` = 1 means drive.
- R11: Every pin other than `LED_PIN` takes its `gpio_dout` and `gpio_dir` bits one clock later, whatever the mode.
- R12: With no set or clear event in a cycle, `connected` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_sel_done | input | 1 | Pulse: selection completed as initiator |
| ev_resp_sel | input | 1 | Pulse: responded to selection or reselection as target |
| ev_arb_won_ll | input | 1 | Pulse: arbitration won in low-level mode |
| ev_disconnect | input | 1 | Pulse: bus connection released |
| ev_bus_reset | input | 1 | Pulse: SCSI bus reset seen |
| pin_ctrl | input | 8 | Pin control byte; bit 5 is LED enable, bit 6 is fetch enable |
| autoload_busy | input | 1 | EEPROM autodownload in progress |
| gpio_dout | input | NUM_PINS | Software pin data register |
| gpio_dir | input | NUM_PINS | Software pin direction register, 1 = drive |
| connected | output | 1 | Connected flag |
| status_byte | output | 8 | Status byte with the connected flag in bit 3 |
| pin_out | output | NUM_PINS | Registered pin data |
| pin_oe | output | NUM_PINS | Registered pin output enable |

## Verification
On every cycle, the assertions check the following:
- each of the three set events raises the flag;
- a clear event wins over a set event;
- the flag holds when no event arrives;
- the LED pin shows the previous flag value and is driven while LED mode is active;
- the LED pin otherwise follows the software registers.

Only the bench scenarios show the following:
- the reset values;
- each gate condition (fetch enable, autodownload) separately taking the pin back from the LED function;
- direction 0 being overridden in LED mode;
- the two-clock latency from an event to the pin;
- the non-LED pins tracking several data patterns.

// File: rtl/scsi_led_pkg.sv
package scsi_led_pkg;
  localparam int CTRL_W          = 8;
  localparam int STAT_W          = 8;
  localparam int CTRL_LED_EN_BIT = 5;
  localparam int CTRL_FETCH_BIT  = 6;
  localparam int STAT_CONN_BIT   = 3;

  // LED mode gate: LED enable set, fetch enable clear, no autodownload
  function automatic logic led_mode_on(input logic led_en, input logic fetch_en,
                                       input logic busy);
    return led_en & ~fetch_en & ~busy;
  endfunction

  // Next connected value: clearing wins over setting
  function automatic logic conn_next(input logic cur, input logic set_any,
                                     input logic clr_any);
    if (clr_any) return 1'b0;
    if (set_any) return 1'b1;
    return cur;
  endfunction
endpackage

// File: rtl/conn_tracker.sv
module conn_tracker
  import scsi_led_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ev_sel_done,
  input  logic ev_resp_sel,
  input  logic ev_arb_won_ll,
  input  logic ev_disconnect,
  input  logic ev_bus_reset,
  output logic set_evt,
  output logic clr_evt,
  output logic connected
);
  logic conn_q;

  assign set_evt = ev_sel_done | ev_resp_sel | ev_arb_won_ll;
  assign clr_evt = ev_disconnect | ev_bus_reset;

  always_ff @(posedge clk) begin
    if (!rst_n) conn_q <= 1'b0;
    else        conn_q <= conn_next(conn_q, set_evt, clr_evt);
  end

  assign connected = conn_q;

  assert_set_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sel_done && !ev_disconnect && !ev_bus_reset) |=> connected);
  assert_set_resp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_resp_sel && !ev_disconnect && !ev_bus_reset) |=> connected);
  assert_set_arb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_arb_won_ll && !ev_disconnect && !ev_bus_reset) |=> connected);
  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_disconnect || ev_bus_reset) |=> !connected);
  assert_clear_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && set_evt) |=> !connected);
  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_sel_done && !ev_resp_sel && !ev_arb_won_ll && !ev_disconnect && !ev_bus_reset)
    |=> $stable(connected));
endmodule

// File: rtl/led_gate.sv
module led_gate
  import scsi_led_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] pin_ctrl,
  input  logic              autoload_busy,
  output logic              led_active
);
  logic led_en, fetch_en;
  assign led_en     = pin_ctrl[CTRL_LED_EN_BIT];
  assign fetch_en   = pin_ctrl[CTRL_FETCH_BIT];
  assign led_active = led_mode_on(led_en, fetch_en, autoload_busy);

  // Any failing condition keeps the pin under software control
  assert_gate_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_en || autoload_busy || !led_en) |-> !led_active);
endmodule

// File: rtl/pin_drive.sv
module pin_drive #(
  parameter int NUM_PINS = 5,
  parameter int LED_PIN  = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                led_active,
  input  logic                connected,
  input  logic [NUM_PINS-1:0] gpio_dout,
  input  logic [NUM_PINS-1:0] gpio_dir,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe
);
  logic [NUM_PINS-1:0] out_d, oe_d;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    if (i == LED_PIN) begin : g_led
      assign out_d[i] = led_active ? connected : gpio_dout[i];
      assign oe_d[i]  = led_active ? 1'b1      : gpio_dir[i];
    end else begin : g_plain
      assign out_d[i] = gpio_dout[i];
      assign oe_d[i]  = gpio_dir[i];
    end
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pin_out[i] <= 1'b0;
        pin_oe[i]  <= 1'b0;
      end else begin
        pin_out[i] <= out_d[i];
        pin_oe[i]  <= oe_d[i];
      end
    end
  end

  assert_led_shows_conn_R8: assert property (@(posedge clk) disable iff (!rst_n)
    led_active |=> (pin_out[LED_PIN] == $past(connected)));
  assert_led_drives_R9: assert property (@(posedge clk) disable iff (!rst_n)
    led_active |=> pin_oe[LED_PIN]);
  assert_sw_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !led_active |=> (pin_out[LED_PIN] == $past(gpio_dout[LED_PIN])));
  assert_sw_dir_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !led_active |=> (pin_oe[LED_PIN] == $past(gpio_dir[LED_PIN])));
endmodule

// File: rtl/scsi_link_led.sv
module scsi_link_led
  import scsi_led_pkg::*;
#(
  parameter int NUM_PINS = 5,
  parameter int LED_PIN  = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ev_sel_done,
  input  logic                ev_resp_sel,
  input  logic                ev_arb_won_ll,
  input  logic                ev_disconnect,
  input  logic                ev_bus_reset,
  input  logic [CTRL_W-1:0]   pin_ctrl,
  input  logic                autoload_busy,
  input  logic [NUM_PINS-1:0] gpio_dout,
  input  logic [NUM_PINS-1:0] gpio_dir,
  output logic                connected,
  output logic [STAT_W-1:0]   status_byte,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe
);
  logic set_evt, clr_evt, led_active;

  conn_tracker u_conn (
    .clk(clk), .rst_n(rst_n),
    .ev_sel_done(ev_sel_done), .ev_resp_sel(ev_resp_sel),
    .ev_arb_won_ll(ev_arb_won_ll), .ev_disconnect(ev_disconnect),
    .ev_bus_reset(ev_bus_reset),
    .set_evt(set_evt), .clr_evt(clr_evt), .connected(connected)
  );

  led_gate u_gate (
    .clk(clk), .rst_n(rst_n), .pin_ctrl(pin_ctrl),
    .autoload_busy(autoload_busy), .led_active(led_active)
  );

  pin_drive #(.NUM_PINS(NUM_PINS), .LED_PIN(LED_PIN)) u_pins (
    .clk(clk), .rst_n(rst_n), .led_active(led_active), .connected(connected),
    .gpio_dout(gpio_dout), .gpio_dir(gpio_dir),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  always_comb begin
    status_byte = '0;
    status_byte[STAT_CONN_BIT] = connected;
  end

  // Set and clear lines are observed only by the tracker and its assertions
  logic evt_unused;
  assign evt_unused = set_evt ^ clr_evt;

  assert_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(status_byte) <= 1);
endmodule

// File: tb/sim_scsi_link_led.sv
module sim_scsi_link_led;
  localparam int N = 5;
  localparam int LP = 0;

  logic clk = 0, rst_n = 0;
  logic sel = 0, resp = 0, arb = 0, disc = 0, brst = 0;
  logic [7:0] ctrl = 0;
  logic busy = 0;
  logic [N-1:0] dout = 0, dir = 0;
  logic conn;
  logic [7:0] stat;
  logic [N-1:0] pout, poe;

  logic [7:0] n_ctrl = 0;
  logic n_busy = 0;
  logic [N-1:0] n_dout = 0, n_dir = 0;

  int checks = 0, fails = 0;

  typedef struct {
    logic conn;
    logic [N-1:0] pout;
    logic [N-1:0] poe;
    string tag;
  } exp_t;
  exp_t q[$];

  logic m_conn = 0;

  always #2 clk = ~clk;

  scsi_link_led #(.NUM_PINS(N), .LED_PIN(LP)) u0 (
    .clk(clk), .rst_n(rst_n),
    .ev_sel_done(sel), .ev_resp_sel(resp), .ev_arb_won_ll(arb),
    .ev_disconnect(disc), .ev_bus_reset(brst),
    .pin_ctrl(ctrl), .autoload_busy(busy), .gpio_dout(dout), .gpio_dir(dir),
    .connected(conn), .status_byte(stat), .pin_out(pout), .pin_oe(poe)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes the expected outcome
  task automatic tick(input logic [4:0] ev, input string tag);
    exp_t e;
    bit led_on;
    @(negedge clk);
    {sel, resp, arb, disc, brst} = ev;
    ctrl = n_ctrl; busy = n_busy; dout = n_dout; dir = n_dir;
    led_on = (n_ctrl[5] == 1'b1) && (n_ctrl[6] == 1'b0) && !n_busy;
    e.pout = n_dout;
    e.poe  = n_dir;
    if (led_on) begin
      e.pout[LP] = m_conn;
      e.poe[LP]  = 1'b1;
    end
    if (ev[1] || ev[0]) m_conn = 1'b0;
    else if (ev[4] || ev[3] || ev[2]) m_conn = 1'b1;
    e.conn = m_conn;
    e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: pops expected items after each edge and compares
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(conn == e.conn, e.tag, "connected", {31'b0, conn}, {31'b0, e.conn});
      chk(stat == {4'b0, e.conn, 3'b0}, "R7", "status_byte", {24'b0, stat},
          {24'b0, 4'b0, e.conn, 3'b0});
      chk(pout == e.pout, e.tag, "pin_out", 32'(pout), 32'(e.pout));
      chk(poe == e.poe, e.tag, "pin_oe", 32'(poe), 32'(e.poe));
    end
  end

  localparam logic [4:0] EV_NONE = 5'b00000, EV_SEL = 5'b10000, EV_RESP = 5'b01000,
                         EV_ARB = 5'b00100, EV_DISC = 5'b00010, EV_BRST = 5'b00001;

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(conn == 0 && stat == 0, "R1", "conn/status at reset", {24'b0, stat}, 0);
    chk(pout == 0 && poe == 0, "R1", "pins at reset", 32'({pout, poe}), 0);
    @(negedge clk); rst_n = 1;

    // Software mode: R10 and R11 with several patterns
    n_dout = 5'b10101; n_dir = 5'b01110; tick(EV_NONE, "R10");
    n_dout = 5'b01011; n_dir = 5'b10001; tick(EV_NONE, "R11");
    n_dout = 5'b11110; n_dir = 5'b11111; tick(EV_NONE, "R11");

    // LED mode on, direction 0 on the LED pin, data 0
    n_ctrl = 8'h20; n_dout = 5'b00110; n_dir = 5'b00110; tick(EV_NONE, "R9");
    tick(EV_SEL, "R2");
    tick(EV_NONE, "R8");
    tick(EV_NONE, "R12");
    tick(EV_DISC, "R5");
    tick(EV_NONE, "R8");
    tick(EV_RESP, "R3");
    tick(EV_NONE, "R12");
    tick(EV_BRST, "R5");
    tick(EV_ARB, "R4");
    tick(EV_SEL | EV_DISC, "R6");
    tick(EV_ARB | EV_BRST, "R6");
    tick(EV_RESP, "R3");

    // Gate conditions fail one by one while connected
    n_ctrl = 8'h60; tick(EV_NONE, "R10");
    n_ctrl = 8'h20; tick(EV_NONE, "R8");
    n_busy = 1; tick(EV_NONE, "R10");
    n_busy = 0; n_ctrl = 8'hDF; tick(EV_NONE, "R10");
    n_ctrl = 8'hBF; n_dout = 5'b01001; n_dir = 5'b10100; tick(EV_NONE, "R9");
    tick(EV_NONE, "R11");
    tick(EV_DISC, "R5");
    tick(EV_NONE, "R8");
    tick(EV_NONE, "R12");

    @(posedge clk); #2;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule